// File: doc/BRIEF.md
# Power-Mode Aware Period Timer

This block is a 16-bit period timer with a small register set. Software writes a control word, a period value and a flag-clear strobe. The counter advances from one of three sources:

- cycles in which an internal tick enable is high;
- rising edges of an external clock, resynchronised into the system clock domain;
- rising edges of the external clock used directly, with no resynchronisation.

When the count reaches the period, it returns to zero and the timer raises a sticky interrupt flag.

A power controller drives two level inputs, one for sleep and one for idle. In sleep the internal tick is absent, and so is the resynchronised path. Only the direct external-clock path keeps counting and detecting matches. A control bit decides whether the timer freezes in idle. When interrupts are enabled, a wake request is asserted from the flag. During sleep it is also asserted straight from an external-domain match that the system domain has not yet absorbed.

Top module: `pm_period_timer`

## Requirements
- R1: While the enable bit (control bit 15) is 0, the count never changes.
- R2: Control bit 1 picks the source. With 0, each system clock cycle with `tick` high counts once. With 1, each rising edge of `ext_clk` counts once and `tick` is ignored.
- R3: With the external source selected, control bit 2 picks the path. With 1, `ext_clk` is resynchronised and counted in the system domain. With 0, the counter advances directly on `ext_clk` rising edges, and `count` shows that counter.
- R4: While `sleep_mode` is high, neither the internal-source path nor the resynchronised path advances. The direct external path keeps counting and detecting matches.
- R5: While `idle_mode` is high, control bit 13 decides the behaviour for every source. With 1 the count is held. With 0 counting continues.
- R6: A count event that finds the count equal to the period sets the count to zero and sets `irq_flag`. Any other count event adds one to the count.
- R7: `irq_flag` stays set until a write to address 2. If a match occurs in the same cycle as that write, the flag stays set.
- R8: `wake_req` is high only when control bit 3 is 1. It then follows `irq_flag`. In sleep it also rises straight after a direct-path match, before the flag is set.
- R9: Reset clears the count, the control word, the period and the flag. `wake_req` is then low.
- R10: A write with `wr_addr` 0 loads the control word. A write with `wr_addr` 1 loads the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk | input | 1 | External count clock |
| tick | input | 1 | Internal count enable, one count per cycle |
| sleep_mode | input | 1 | Power controller: sleep |
| idle_mode | input | 1 | Power controller: idle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 period, 2 flag clear) |
| wr_data | input | 16 | Register write data |
| count | output | 16 | Current count of the active counter |
| irq_flag | output | 1 | Sticky period-match flag |
| wake_req | output | 1 | Wake-up request to the power controller |

## Verification
The bench targets the sleep gating in each source mode:

- A design that kept the internal or resynchronised path running in sleep would move the count.
- A design that stopped the direct path would lose the match and the wake request.

The bench samples `wake_req` one nanosecond after a direct-path match in sleep. A design that waited for the synchronised flag would show it low there.

In the same cycle, the bench sends a flag-clear write and a match. A design with clear priority would drop the flag.

The bench also checks wrap-around at a period of zero and the hold of the count in idle with the stop bit set. It checks that `tick` is ignored when the external source is selected.

// File: rtl/pmt_pkg.sv
`timescale 1ns/1ps
package pmt_pkg;
  localparam int CTRL_EN_BIT   = 15;
  localparam int CTRL_SIDL_BIT = 13;
  localparam int CTRL_IE_BIT   = 3;
  localparam int CTRL_SYNC_BIT = 2;
  localparam int CTRL_SRC_BIT  = 1;
  localparam int ADDR_W        = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CTRL   = 2'd0,
    ADR_PERIOD = 2'd1,
    ADR_FLAGCL = 2'd2
  } reg_addr_e;

  typedef struct packed {
    logic en;
    logic stop_idle;
    logic irq_en;
    logic ext_sync;
    logic ext_src;
  } ctrl_t;
endpackage

// File: rtl/pmt_sync2.sv
`timescale 1ns/1ps
module pmt_sync2 (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [1:0] stg_q;
  logic [1:0] stg_d;

  always_comb stg_d = {stg_q[0], d};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= '0;
    else         stg_q <= stg_d;
  end

  assign q = stg_q[1];
endmodule

// File: rtl/pmt_count_core.sv
`timescale 1ns/1ps
module pmt_count_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] period,
  output logic [W-1:0] cnt,
  output logic         hit
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    hit   = run && (cnt_q == period);
    cnt_d = cnt_q;
    if (run) cnt_d = hit ? '0 : cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pmt_regs.sv
`timescale 1ns/1ps
module pmt_regs
  import pmt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic              match,
  output ctrl_t             ctrl,
  output logic [W-1:0]      period,
  output logic              flag
);
  ctrl_t        ctrl_q, ctrl_d;
  logic [W-1:0] per_q, per_d;
  logic         flag_q, flag_d;
  logic         wr_ctrl, wr_per, wr_clr;

  always_comb begin
    wr_ctrl = wr_en && (wr_addr == ADR_CTRL);
    wr_per  = wr_en && (wr_addr == ADR_PERIOD);
    wr_clr  = wr_en && (wr_addr == ADR_FLAGCL);

    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.en        = wr_data[CTRL_EN_BIT];
      ctrl_d.stop_idle = wr_data[CTRL_SIDL_BIT];
      ctrl_d.irq_en    = wr_data[CTRL_IE_BIT];
      ctrl_d.ext_sync  = wr_data[CTRL_SYNC_BIT];
      ctrl_d.ext_src   = wr_data[CTRL_SRC_BIT];
    end

    per_d  = wr_per ? wr_data : per_q;
    // a match outranks a clear in the same cycle
    flag_d = match ? 1'b1 : (wr_clr ? 1'b0 : flag_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      per_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      per_q  <= per_d;
      flag_q <= flag_d;
    end
  end

  assign ctrl   = ctrl_q;
  assign period = per_q;
  assign flag   = flag_q;
endmodule

// File: rtl/pm_period_timer.sv
`timescale 1ns/1ps
module pm_period_timer
  import pmt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clk,
  input  logic              tick,
  input  logic              sleep_mode,
  input  logic              idle_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      count,
  output logic              irq_flag,
  output logic              wake_req
);
  logic         rst_sys_n, rst_ext_n;
  ctrl_t        ctrl;
  logic [W-1:0] period;
  logic         cfg_en, cfg_sidl, cfg_ie, cfg_sync, cfg_src;
  logic         ext_s, ext_prev_q, ext_rise;
  logic         async_mode, idle_hold, sys_run, ext_run;
  logic [W-1:0] sys_cnt, ext_cnt;
  logic         sys_hit, ext_hit;
  logic         ext_tog_q, ext_tog_d;
  logic         tog_s, tog_prev_q, ext_match, ext_pend;
  logic         match_any, flag_clr;

  // reset release aligned to each clock domain
  pmt_sync2 u_rst_sys (.clk(clk),     .arst_n(rst_n), .d(1'b1), .q(rst_sys_n));
  pmt_sync2 u_rst_ext (.clk(ext_clk), .arst_n(rst_n), .d(1'b1), .q(rst_ext_n));

  pmt_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_sys_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .match(match_any), .ctrl(ctrl), .period(period),
    .flag(irq_flag)
  );

  always_comb begin
    cfg_en   = ctrl.en;
    cfg_sidl = ctrl.stop_idle;
    cfg_ie   = ctrl.irq_en;
    cfg_sync = ctrl.ext_sync;
    cfg_src  = ctrl.ext_src;
    flag_clr = wr_en && (wr_addr == ADR_FLAGCL);
  end

  // resynchronised external edge for the system-domain path
  pmt_sync2 u_ext_sync (.clk(clk), .arst_n(rst_sys_n), .d(ext_clk), .q(ext_s));

  always_ff @(posedge clk or negedge rst_sys_n) begin
    if (!rst_sys_n) ext_prev_q <= 1'b0;
    else            ext_prev_q <= ext_s;
  end

  always_comb begin
    ext_rise   = ext_s && !ext_prev_q;
    async_mode = cfg_en && cfg_src && !cfg_sync;
    idle_hold  = idle_mode && cfg_sidl;
    sys_run    = cfg_en && !sleep_mode && !idle_hold &&
                 (cfg_src ? (cfg_sync && ext_rise) : tick);
    // control and idle are quasi-static relative to ext_clk
    ext_run    = async_mode && !idle_hold;
  end

  pmt_count_core #(.W(W)) u_sys_core (
    .clk(clk), .rst_n(rst_sys_n), .run(sys_run), .period(period),
    .cnt(sys_cnt), .hit(sys_hit)
  );

  pmt_count_core #(.W(W)) u_ext_core (
    .clk(ext_clk), .rst_n(rst_ext_n), .run(ext_run), .period(period),
    .cnt(ext_cnt), .hit(ext_hit)
  );

  // external-domain match crosses as a toggle
  always_comb ext_tog_d = ext_tog_q ^ ext_hit;

  always_ff @(posedge ext_clk or negedge rst_ext_n) begin
    if (!rst_ext_n) ext_tog_q <= 1'b0;
    else            ext_tog_q <= ext_tog_d;
  end

  pmt_sync2 u_tog_sync (.clk(clk), .arst_n(rst_sys_n), .d(ext_tog_q), .q(tog_s));

  always_ff @(posedge clk or negedge rst_sys_n) begin
    if (!rst_sys_n) tog_prev_q <= 1'b0;
    else            tog_prev_q <= tog_s;
  end

  always_comb begin
    ext_match = tog_s ^ tog_prev_q;
    ext_pend  = ext_tog_q ^ tog_prev_q;
    match_any = sys_hit || ext_match;
    wake_req  = cfg_ie && (irq_flag || (sleep_mode && ext_pend));
    count     = async_mode ? ext_cnt : sys_cnt;
  end
endmodule

// File: rtl/pmt_checker.sv
`timescale 1ns/1ps
module pmt_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         stop_idle,
  input logic         irq_en,
  input logic         sleep_mode,
  input logic         idle_mode,
  input logic [W-1:0] sys_cnt,
  input logic         irq_flag,
  input logic         wake_req,
  input logic         flag_clr,
  input logic         match_any
);
  p_off_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(sys_cnt));

  p_sleep_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_mode |=> $stable(sys_cnt));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_mode && stop_idle) |=> $stable(sys_cnt));

  p_flag_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(match_any));

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !flag_clr) |=> irq_flag);

  p_wake_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> irq_en);

  p_wake_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && irq_en) |-> wake_req);
endmodule

bind pm_period_timer pmt_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_sys_n), .en(cfg_en), .stop_idle(cfg_sidl),
  .irq_en(cfg_ie), .sleep_mode(sleep_mode), .idle_mode(idle_mode),
  .sys_cnt(sys_cnt), .irq_flag(irq_flag), .wake_req(wake_req),
  .flag_clr(flag_clr), .match_any(match_any)
);

// File: tb/tb_pm_period_timer.sv
`timescale 1ns/1ps
module tb_pm_period_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_clk = 1'b0;
  logic        tick = 1'b0;
  logic        sleep_mode = 1'b0;
  logic        idle_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [15:0] count;
  logic        irq_flag;
  logic        wake_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // model state
  logic [15:0] m_sys, m_ext, m_per;
  bit m_flag, m_en, m_sidl, m_ie, m_sync, m_src;

  always #4 clk = ~clk;

  pm_period_timer dut (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .tick(tick),
    .sleep_mode(sleep_mode), .idle_mode(idle_mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .count(count),
    .irq_flag(irq_flag), .wake_req(wake_req)
  );

  function automatic logic [15:0] mk_ctrl(bit en, bit sidl, bit ie, bit sync, bit src);
    return {en, 1'b0, sidl, 9'd0, ie, sync, src, 1'b0};
  endfunction

  function automatic bit is_async();
    return m_en && m_src && !m_sync;
  endfunction

  function automatic logic [15:0] exp_count();
    return is_async() ? m_ext : m_sys;
  endfunction

  task automatic step_sys();
    if (m_sys == m_per) begin m_sys = '0; m_flag = 1'b1; end
    else m_sys = m_sys + 16'd1;
  endtask

  task automatic step_ext();
    if (m_ext == m_per) begin m_ext = '0; m_flag = 1'b1; end
    else m_ext = m_ext + 16'd1;
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    #1;
    chk(req, count, exp_count(), "count");
    chk(req, {15'd0, irq_flag}, {15'd0, m_flag}, "irq_flag");
    chk(req, {15'd0, wake_req}, {15'd0, (m_ie && m_flag)}, "wake_req");
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      2'd0: begin
        m_en = d[15]; m_sidl = d[13]; m_ie = d[3]; m_sync = d[2]; m_src = d[1];
      end
      2'd1: m_per = d;
      2'd2: m_flag = 1'b0;
      default: ;
    endcase
  endtask

  task automatic set_ctrl(bit en, bit sidl, bit ie, bit sync, bit src);
    wr(2'd0, mk_ctrl(en, sidl, ie, sync, src));
  endtask

  task automatic tick_once();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    if (m_en && !m_src && !sleep_mode && !(idle_mode && m_sidl)) step_sys();
  endtask

  task automatic ext_pulse();
    @(negedge clk); ext_clk = 1'b1;
    repeat (4) @(negedge clk);
    ext_clk = 1'b0;
    repeat (4) @(negedge clk);
    if (is_async()) begin
      if (!(idle_mode && m_sidl)) step_ext();
    end else if (m_en && m_src && m_sync && !sleep_mode && !(idle_mode && m_sidl)) begin
      step_sys();
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    m_sys = '0; m_ext = '0; m_per = '0; m_flag = 0;
    m_en = 0; m_sidl = 0; m_ie = 0; m_sync = 0; m_src = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9: reset state
    check_all("R9");
    // bring the external-domain reset out (two edges, timer disabled)
    ext_pulse(); ext_pulse();
    check_all("R9");

    // R1: disabled timer ignores ticks
    wr(2'd1, 16'd3);                 // R10 period at address 1
    repeat (3) tick_once();
    check_all("R1");

    // R6 / R10: internal source, wrap through period 3
    set_ctrl(1, 0, 0, 0, 0);         // R10 control at address 0
    repeat (5) tick_once();
    check_all("R6");                 // count 1, flag 1, no wake (ie off)

    // R7: clear by write to address 2
    wr(2'd2, 16'd0);
    check_all("R7");

    // R2 / R3: synchronised external source ignores tick
    set_ctrl(1, 0, 0, 1, 1);
    repeat (2) tick_once();
    check_all("R2");
    repeat (2) ext_pulse();
    check_all("R3");

    // R5: idle with stop bit holds, without stop bit continues
    set_ctrl(1, 1, 0, 0, 0);
    idle_mode = 1'b1;
    repeat (3) tick_once();
    check_all("R5");
    set_ctrl(1, 0, 0, 0, 0);
    repeat (2) tick_once();
    check_all("R5");
    idle_mode = 1'b0;

    // R4: sleep stops internal and synchronised external paths
    sleep_mode = 1'b1;
    repeat (3) tick_once();
    check_all("R4");
    set_ctrl(1, 0, 0, 1, 1);
    repeat (2) ext_pulse();
    check_all("R4");

    // R8 / R4: async path in sleep, wake before flag
    wr(2'd2, 16'd0);
    wr(2'd1, 16'd0);
    set_ctrl(1, 0, 1, 0, 1);
    @(negedge clk); ext_clk = 1'b1;
    #1;
    chk("R8", {15'd0, wake_req}, 16'd1, "early wake_req");
    chk("R8", {15'd0, irq_flag}, 16'd0, "early irq_flag");
    repeat (4) @(negedge clk);
    ext_clk = 1'b0;
    repeat (4) @(negedge clk);
    step_ext();
    check_all("R4");
    sleep_mode = 1'b0;

    // R7: match in the same cycle as a clear keeps the flag
    wr(2'd1, 16'd2);
    set_ctrl(1, 0, 0, 0, 0);
    while (m_sys != 16'd2) tick_once();
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'd0;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    m_flag = 1'b0;
    step_sys();
    check_all("R7");

    // random mix over all modes and power states
    for (int it = 0; it < 60; it++) begin
      sleep_mode = ($urandom_range(3, 0) == 0);
      idle_mode  = ($urandom_range(2, 0) == 0);
      wr(2'd1, 16'($urandom_range(4, 0)));
      set_ctrl($urandom_range(4, 0) != 0, $urandom_range(1, 0) != 0,
               $urandom_range(1, 0) != 0, $urandom_range(1, 0) != 0,
               $urandom_range(1, 0) != 0);
      for (int e = 0; e < 6; e++) begin
        case ($urandom_range(5, 0))
          0, 1, 2: tick_once();
          3, 4:    ext_pulse();
          default: wr(2'd2, 16'd0);
        endcase
      end
      check_all("R6");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule